// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt addressing request into a bitmask over a parameterised set of local interrupt units. Each bit says whether that unit accepts the interrupt. Every unit exposes its own addressing state to the resolver. That state is an 8-bit short ID and a 32-bit extended ID, a flag for the extended (32-bit) addressing mode, an 8-bit logical destination with a flat-or-cluster model bit, and a 32-bit extended logical destination. Units in the short mode and units in the extended mode can sit side by side, and each kind has its own broadcast rule.

A request has several parts. The first is a 32-bit destination value. The second is a physical/logical mode bit. The third is a 2-bit shorthand that can bypass the destination: to the sender, to everyone, or to everyone but the sender. Last is a lowest-priority flag, which reduces the mask to a single target, the lowest-numbered unit that the request selected. A one-cycle strobe starts the request. The mask appears in a register on the next clock edge, together with a one-cycle done flag.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset `done` is 0 and `dest_mask` is all zeros. `done` is 1 in exactly the cycle after a cycle with `req_valid` high. `dest_mask` loads only on such a strobe and otherwise keeps its value.
- R2: With shorthand 0, physical mode (`req_logical`=0) and a destination of 32'hFFFF_FFFF, every unit is selected.
- R3: With shorthand 0 and physical mode, a unit in extended mode (`unit_x2`=1) matches when its 32-bit extended ID equals the whole destination. A unit in short mode matches when its 8-bit ID equals destination bits [7:0].
- R4: With shorthand 0, physical mode and a destination of exactly 32'h0000_00FF, every short-mode unit is selected. An extended-mode unit is selected only if its extended ID equals 32'hFF.
- R5: With shorthand 0, logical mode (`req_logical`=1) and a destination of 32'hFFFF_FFFF, every extended-mode unit is selected. Short-mode units are still judged by the short logical rules (R7, R8) on byte 8'hFF.
- R6: With shorthand 0 and logical mode, an extended-mode unit matches when destination bits [31:16] equal its extended logical bits [31:16] and destination bits [15:0] AND its extended logical bits [15:0] is nonzero.
- R7: With shorthand 0 and logical mode, a short-mode unit with `unit_cluster`=0 (flat) matches when destination bits [7:0] AND its logical destination is nonzero.
- R8: With shorthand 0 and logical mode, a short-mode unit with `unit_cluster`=1 matches under two conditions. First, destination bits [7:4] equal 4'hF or equal its logical bits [7:4]. Second, destination bits [3:0] AND its logical bits [3:0] is nonzero.
- R9: Shorthand 1 selects only unit `req_sender`, whatever the destination and mode.
- R10: Shorthand 2 selects all units. Shorthand 3 selects all units except `req_sender`.
- R11: With `req_lowest`=1, only the lowest-indexed bit of the mask from R2 to R10 is kept. An empty mask stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_dest | input | 32 | Destination value |
| req_logical | input | 1 | 0 physical, 1 logical |
| req_shorthand | input | 2 | 0 destination, 1 self, 2 all, 3 all but self |
| req_lowest | input | 1 | Lowest-priority delivery: keep one target |
| req_sender | input | $clog2(NUM_UNITS) | Index of the requesting unit |
| unit_id | input | NUM_UNITS*8 | Short IDs, unit i at bits [8i+7:8i] |
| unit_ext_id | input | NUM_UNITS*32 | Extended IDs, unit i at [32i+31:32i] |
| unit_x2 | input | NUM_UNITS | Extended addressing mode per unit |
| unit_logdst | input | NUM_UNITS*8 | Short logical destinations |
| unit_cluster | input | NUM_UNITS | 1 cluster model, 0 flat model |
| unit_ext_logdst | input | NUM_UNITS*32 | Extended logical destinations |
| done | output | 1 | Result valid, one cycle |
| dest_mask | output | NUM_UNITS | Registered accepting-unit bitmask |

## Verification
The assertions assume that `req_sender` is below NUM_UNITS. They also assume that the request fields are stable in the strobe cycle. The self-shorthand properties in particular depend on a sender index that is in range. The bench drives every request field in the same negative-edge cycle as the strobe. It uses only sender indices 0 to 7 with eight units. It holds the unit tables constant while each request is in flight.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  localparam logic [31:0] ALL_ONES32 = 32'hFFFF_FFFF;
  localparam logic [7:0]  SHORT_BCAST = 8'hFF;
  localparam logic [3:0]  ANY_CLUSTER = 4'hF;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  // physical-mode acceptance for one unit
  function automatic logic phys_hit(input logic [31:0] dest, input logic x2,
                                    input logic [7:0] id, input logic [31:0] ext_id);
    logic by_id;
    by_id = x2 ? (ext_id == dest) : (id == dest[7:0]);
    return (dest == ALL_ONES32) || by_id ||
           (!x2 && dest == {24'd0, SHORT_BCAST});
  endfunction

  // extended-mode logical acceptance: cluster word equal, members overlap
  function automatic logic x2_logical_hit(input logic [31:0] dest,
                                          input logic [31:0] ext_log);
    return (dest[31:16] == ext_log[31:16]) && (|(dest[15:0] & ext_log[15:0]));
  endfunction

  // short-mode logical acceptance, flat or cluster model
  function automatic logic short_logical_hit(input logic [7:0] dbyte,
                                             input logic cluster_model,
                                             input logic [7:0] logdst);
    logic grp_ok;
    grp_ok = (dbyte[7:4] == ANY_CLUSTER) || (dbyte[7:4] == logdst[7:4]);
    if (cluster_model) return grp_ok && (|(dbyte[3:0] & logdst[3:0]));
    return |(dbyte & logdst);
  endfunction

endpackage

// File: rtl/unit_match.sv
module unit_match
  import irq_dest_pkg::*;
(
  input  logic [31:0] dest,
  input  logic        logical,
  input  logic        x2,
  input  logic [7:0]  id,
  input  logic [31:0] ext_id,
  input  logic [7:0]  logdst,
  input  logic        cluster_model,
  input  logic [31:0] ext_logdst,
  output logic        hit
);
  logic phys_sel;
  logic log_sel;

  always_comb begin
    phys_sel = phys_hit(dest, x2, id, ext_id);
    if (x2)
      log_sel = (dest == ALL_ONES32) || x2_logical_hit(dest, ext_logdst);
    else
      log_sel = short_logical_hit(dest[7:0], cluster_model, logdst);
    hit = logical ? log_sel : phys_sel;
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_vec
);
  // isolate the lowest set bit; zero stays zero
  assign out_vec = in_vec & (~in_vec + {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [31:0]               req_dest,
  input  logic                      req_logical,
  input  logic [1:0]                req_shorthand,
  input  logic                      req_lowest,
  input  logic [IDX_W-1:0]          req_sender,
  input  logic [NUM_UNITS*8-1:0]    unit_id,
  input  logic [NUM_UNITS*32-1:0]   unit_ext_id,
  input  logic [NUM_UNITS-1:0]      unit_x2,
  input  logic [NUM_UNITS*8-1:0]    unit_logdst,
  input  logic [NUM_UNITS-1:0]      unit_cluster,
  input  logic [NUM_UNITS*32-1:0]   unit_ext_logdst,
  output logic                      done,
  output logic [NUM_UNITS-1:0]      dest_mask
);
  localparam logic [NUM_UNITS-1:0] ONE_VEC = {{(NUM_UNITS-1){1'b0}}, 1'b1};

  logic [NUM_UNITS-1:0] match_vec;    // destination logic result
  logic [NUM_UNITS-1:0] sender_oh;    // sender as one-hot
  logic [NUM_UNITS-1:0] routed_vec;   // after shorthand
  logic [NUM_UNITS-1:0] single_vec;   // lowest set bit of routed_vec
  logic [NUM_UNITS-1:0] next_mask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    unit_match u_match (
      .dest          (req_dest),
      .logical       (req_logical),
      .x2            (unit_x2[u]),
      .id            (unit_id[u*8 +: 8]),
      .ext_id        (unit_ext_id[u*32 +: 32]),
      .logdst        (unit_logdst[u*8 +: 8]),
      .cluster_model (unit_cluster[u]),
      .ext_logdst    (unit_ext_logdst[u*32 +: 32]),
      .hit           (match_vec[u])
    );
  end

  assign sender_oh = ONE_VEC << req_sender;

  always_comb begin
    case (shorthand_e'(req_shorthand))
      SH_SELF:   routed_vec = sender_oh;
      SH_ALL:    routed_vec = '1;
      SH_OTHERS: routed_vec = ~sender_oh;
      default:   routed_vec = match_vec;
    endcase
  end

  lowest_pick #(.W(NUM_UNITS)) u_pick (
    .in_vec  (routed_vec),
    .out_vec (single_vec)
  );

  assign next_mask = req_lowest ? single_vec : routed_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      dest_mask <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) dest_mask <= next_mask;
    end
  end

  // ---------------- assertions ----------------
  a_r1_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  a_r1_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(dest_mask));
  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lowest) |=> $onehot0(dest_mask));
  a_r11_pick_within_set: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((single_vec & ~routed_vec) == '0));
  a_r9_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd1) |=>
      ($countones(dest_mask) == 1 && dest_mask[$past(req_sender)]));
  a_r10_sender_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd3) |=> !dest_mask[$past(req_sender)]);
  a_r10_all_units: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd2 && !req_lowest) |=> (&dest_mask));
  a_r2_phys_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd0 && !req_logical &&
     req_dest == 32'hFFFF_FFFF && !req_lowest) |=> (&dest_mask));
endmodule

// File: tb/irq_dest_resolver_tb_top.sv
module irq_dest_resolver_tb_top;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic req_lowest = 1'b0;
  logic [IW-1:0] req_sender = '0;
  logic [N*8-1:0] unit_id;
  logic [N*32-1:0] unit_ext_id;
  logic [N-1:0] unit_x2;
  logic [N*8-1:0] unit_logdst;
  logic [N-1:0] unit_cluster;
  logic [N*32-1:0] unit_ext_logdst;
  logic done;
  logic [N-1:0] dest_mask;

  int tests_run = 0;
  int tests_failed = 0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];
  logic [N-1:0] last_exp = '0;

  always #2 clk = ~clk;

  irq_dest_resolver #(.NUM_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_lowest(req_lowest), .req_sender(req_sender), .unit_id(unit_id),
    .unit_ext_id(unit_ext_id), .unit_x2(unit_x2), .unit_logdst(unit_logdst),
    .unit_cluster(unit_cluster), .unit_ext_logdst(unit_ext_logdst),
    .done(done), .dest_mask(dest_mask)
  );

  // population: 0-2 short flat, 3-5 short cluster, 6-7 extended mode
  initial begin
    for (int i = 0; i < N; i++) begin
      unit_id[i*8 +: 8] = 8'h10 + 8'(i);
      unit_ext_id[i*32 +: 32] = 32'h100 + 32'(i);
      unit_x2[i] = (i >= 6);
      unit_cluster[i] = (i >= 3 && i <= 5);
      unit_logdst[i*8 +: 8] = 8'(1 << i);
      unit_ext_logdst[i*32 +: 32] = 32'h0;
    end
    unit_logdst[3*8 +: 8] = 8'h21;
    unit_logdst[4*8 +: 8] = 8'h22;
    unit_logdst[5*8 +: 8] = 8'h31;
    unit_ext_id[6*32 +: 32] = 32'h0001_2345;
    unit_ext_id[7*32 +: 32] = 32'h0000_00FF;
    unit_ext_logdst[6*32 +: 32] = 32'h0001_0001;
    unit_ext_logdst[7*32 +: 32] = 32'h0001_0002;
  end

  // reference model written from the requirements, unit by unit
  function automatic logic [N-1:0] model(input logic [31:0] d, input logic lg,
      input logic [1:0] sh, input logic low, input int snd);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) begin
      logic acc;
      logic [7:0] ld;
      ld = unit_logdst[i*8 +: 8];
      acc = 1'b0;
      if (sh == 2'd1) acc = (i == snd);
      else if (sh == 2'd2) acc = 1'b1;
      else if (sh == 2'd3) acc = (i != snd);
      else if (!lg) begin
        if (d == 32'hFFFF_FFFF) acc = 1'b1;
        else if (unit_x2[i]) acc = (unit_ext_id[i*32 +: 32] == d);
        else acc = (d == 32'hFF) || (unit_id[i*8 +: 8] == d[7:0]);
      end else if (unit_x2[i]) begin
        acc = (d == 32'hFFFF_FFFF) ||
              ((unit_ext_logdst[i*32+16 +: 16] == d[31:16]) &&
               ((unit_ext_logdst[i*32 +: 16] & d[15:0]) != 0));
      end else if (unit_cluster[i]) begin
        acc = ((d[7:4] == 4'hF) || (d[7:4] == ld[7:4])) && ((d[3:0] & ld[3:0]) != 0);
      end else begin
        acc = ((d[7:0] & ld) != 0);
      end
      m[i] = acc;
    end
    if (low) begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (seen) m[i] = 1'b0;
        else if (m[i]) seen = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic drive(input logic [31:0] d, input logic lg, input logic [1:0] sh,
                       input logic low, input int snd, input string tag,
                       input logic [N-1:0] hand_exp);
    logic [N-1:0] e;
    e = model(d, lg, sh, low, snd);
    if (e !== hand_exp) begin
      $display("bench model disagrees with table for %s: %b vs %b", tag, e, hand_exp);
      tests_failed++;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
    @(negedge clk);
    req_dest = d; req_logical = lg; req_shorthand = sh;
    req_lowest = low; req_sender = IW'(snd); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      tests_run++;
      if (exp_q.size() == 0) begin
        tests_failed++;
        $display("FAIL R1: done without request, mask=%b expected no done", dest_mask);
      end else begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dest_mask !== e) begin
          tests_failed++;
          $display("FAIL %s: mask=%b expected %b", t, dest_mask, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    tests_run++; tests_failed++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tests_run++;
    if (done !== 1'b0 || dest_mask !== '0) begin
      tests_failed++;
      $display("FAIL R1 reset: done=%b mask=%b expected 0 and 0", done, dest_mask);
    end
    rst_n = 1'b1;
    @(negedge clk);

    drive(32'hFFFF_FFFF, 0, 0, 0, 0, "R2 physical broadcast", 8'hFF);
    drive(32'h0000_0012, 0, 0, 0, 0, "R3 short id", 8'h04);
    drive(32'h0001_2345, 0, 0, 0, 0, "R3 extended id", 8'h40);
    drive(32'h0000_0112, 0, 0, 0, 0, "R3 low byte only", 8'h04);
    drive(32'h0000_00FF, 0, 0, 0, 0, "R4 short broadcast", 8'hBF);
    drive(32'hFFFF_FFFF, 1, 0, 0, 0, "R5 logical broadcast", 8'hFF);
    drive(32'h0001_0003, 1, 0, 0, 0, "R6 extended cluster", 8'hC3);
    drive(32'h0002_0001, 1, 0, 0, 0, "R6 cluster mismatch", 8'h01);
    drive(32'h0000_0005, 1, 0, 0, 0, "R7 flat", 8'h05);
    drive(32'h0000_0023, 1, 0, 0, 0, "R8 cluster 2", 8'h1B);
    drive(32'h0000_00F1, 1, 0, 0, 0, "R8 all clusters", 8'h29);
    drive(32'h0000_0077, 1, 1, 0, 5, "R9 self ignores dest", 8'h20);
    drive(32'hFFFF_FFFF, 0, 2, 0, 3, "R10 all", 8'hFF);
    drive(32'h0000_0000, 0, 3, 0, 0, "R10 all but sender", 8'hFE);
    drive(32'h0000_0023, 1, 0, 1, 0, "R11 lowest of set", 8'h01);
    drive(32'h0001_2345, 0, 0, 1, 0, "R11 lowest single", 8'h40);
    drive(32'h0000_0077, 0, 0, 1, 0, "R11 empty stays empty", 8'h00);
    drive(32'h0000_0000, 0, 3, 1, 0, "R11 lowest after shorthand", 8'h02);

    repeat (4) @(negedge clk);
    tests_run++;
    if (dest_mask !== last_exp || done !== 1'b0) begin
      tests_failed++;
      $display("FAIL R1 hold: mask=%b done=%b expected %b and 0", dest_mask, done, last_exp);
    end
    tests_run++;
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule